// File: doc/BRIEF.md
# Block-Lock Write Protection Unit

This block decides, one request at a time, whether a write may go ahead. Two kinds of write are judged: a write to an address of the memory array and a write to the protection settings. The unit holds those settings itself: a hardware-protect enable, a two-bit lock level, a two-bit watchdog period and a software flag. It combines them with a write-enable latch and the level of an external protect pin.

A controller presents one command per clock. The unit answers a write with a one-cycle grant or deny pulse in the following cycle. In that same cycle it applies any change to its own settings. The lock level closes the upper quarter, the upper half or the whole array. When the protect enable is set and the pin is held low, the settings themselves are frozen. The locked part of the array then behaves as in-circuit programmable ROM.

The array holds 2^ADDR_W bytes, and the lock boundaries follow that size. Nonvolatile timing is handled outside the block and is reported through a busy input.

Top module: `blocklock_guard`

## Requirements
- R1: After reset the write-enable latch and the flag are 0, grant and deny are low, and the protect enable, watchdog and lock bits take bits 7, 5:4 and 3:2 of parameter RST_STATUS.
- R2: The status output is {protect enable, flag, watchdog[1:0], lock[1:0], write-enable latch, busy} from bit 7 down to bit 0. Bit 0 follows the busy input in the same cycle.
- R3: Command codes 1/2 set/clear the latch and codes 3/4 set/clear the flag, with effect in the next cycle. Codes 0 and 7 change nothing.
- R4: A write command (5 = settings write, 6 = array write) produces exactly one of grant or deny, for one cycle, in the cycle after the request. Other codes produce neither.
- R5: With the latch at 0, every write is denied.
- R6: Lock level 00 locks nothing, 01 the top quarter (two address MSBs 11), 10 the top half (MSB 1), 11 the whole array. An array write is denied at a locked address and granted elsewhere when the latch is 1, whatever the pin level.
- R7: With the latch at 1, a settings write is denied when protect enable is 1 and the pin is low, and granted otherwise.
- R8: A granted settings write loads bits 7, 5:4 and 3:2 of the data and ignores data bits 6, 1 and 0. A denied write changes no setting.
- R9: A granted write clears the latch. A denied write leaves the latch unchanged.
- R10: The decision uses the pin level of the request cycle only. A pin drop in the cycle after the request does not undo a settings write already granted.
- R11: The quarter and half boundaries are derived from ADDR_W (for ADDR_W=13 they are 0x1800 and 0x1000).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd | input | 3 | Command code for this cycle |
| addr | input | ADDR_W | Array address of an array write |
| wr_data | input | 8 | New settings for a settings write |
| pin_hi | input | 1 | Level of the protect pin (low = protect) |
| nv_busy | input | 1 | External nonvolatile write in progress |
| grant | output | 1 | Write allowed (pulse) |
| deny | output | 1 | Write refused (pulse) |
| status | output | 8 | Status byte |

## Verification
On every cycle, the assertions check the following. Grant and deny never coincide. Any write with the latch clear is refused. A settings write under an active pin freeze is refused, and a refused write leaves the settings untouched. A whole-array lock never grants. A grant always leaves the latch clear. Only the bench scenarios show the rest: the exact quarter and half boundary addresses, the ignored data bits, the flag commands, the pin dropping just after a granted settings write, and the full ROM-mode sequence. These are checked against a behavioural model that is compared with the status, grant and deny outputs on every clock, over directed and pseudo-random command streams.

// File: rtl/blg_pkg.sv
package blg_pkg;
   typedef enum logic [2:0] {
      CMD_NOP       = 3'd0,
      CMD_LATCH_SET = 3'd1,
      CMD_LATCH_CLR = 3'd2,
      CMD_FLAG_SET  = 3'd3,
      CMD_FLAG_CLR  = 3'd4,
      CMD_STAT_WR   = 3'd5,
      CMD_ARR_WR    = 3'd6,
      CMD_RSVD      = 3'd7
   } cmd_e;

   typedef struct packed {
      logic       pen;
      logic       flag;
      logic [1:0] wd;
      logic [1:0] bl;
      logic       wel;
      logic       busy;
   } stat_t;

   localparam int STAT_W = $bits(stat_t);
endpackage

// File: rtl/blg_lock_map.sv
module blg_lock_map #(
   parameter int ADDR_W = 13
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic [1:0]        lvl,
   output logic              locked
);
   localparam int TOP = ADDR_W - 1;

   initial begin
      assert (ADDR_W >= 2 && ADDR_W <= 32)
         else $error("blg_lock_map: ADDR_W out of range");
   end

   logic in_quarter, in_half;
   always_comb begin
      in_quarter = addr[TOP] & addr[TOP-1];
      in_half    = addr[TOP];
      unique case (lvl)
         2'b00:   locked = 1'b0;
         2'b01:   locked = in_quarter;
         2'b10:   locked = in_half;
         default: locked = 1'b1;
      endcase
   end
endmodule

// File: rtl/blg_policy.sv
module blg_policy
   import blg_pkg::*;
(
   input  cmd_e op,
   input  logic wel,
   input  logic pen,
   input  logic pin_hi,
   input  logic arr_locked,
   output logic is_write,
   output logic ok
);
   logic frozen;
   always_comb begin
      frozen   = pen & ~pin_hi;
      is_write = (op == CMD_STAT_WR) || (op == CMD_ARR_WR);
      unique case (op)
         CMD_STAT_WR: ok = wel & ~frozen;
         CMD_ARR_WR:  ok = wel & ~arr_locked;
         default:     ok = 1'b0;
      endcase
   end
endmodule

// File: rtl/blg_status.sv
module blg_status
   import blg_pkg::*;
#(
   parameter logic [7:0] RST_STATUS = 8'h00
) (
   input  logic       clk,
   input  logic       rst_n,
   input  cmd_e       op,
   input  logic       ok,
   input  logic [7:0] din,
   input  logic       nv_busy,
   output stat_t      st
);
   logic       pen_q, flag_q, wel_q;
   logic [1:0] wd_q, bl_q;
   logic       unused_din;
   assign unused_din = ^{din[6], din[1:0], RST_STATUS[6], RST_STATUS[1:0]};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pen_q  <= RST_STATUS[7];
         wd_q   <= RST_STATUS[5:4];
         bl_q   <= RST_STATUS[3:2];
         flag_q <= 1'b0;
         wel_q  <= 1'b0;
      end else begin
         unique case (op)
            CMD_LATCH_SET: wel_q  <= 1'b1;
            CMD_LATCH_CLR: wel_q  <= 1'b0;
            CMD_FLAG_SET:  flag_q <= 1'b1;
            CMD_FLAG_CLR:  flag_q <= 1'b0;
            CMD_STAT_WR: if (ok) begin
               pen_q <= din[7];
               wd_q  <= din[5:4];
               bl_q  <= din[3:2];
               wel_q <= 1'b0;
            end
            CMD_ARR_WR: if (ok) wel_q <= 1'b0;
            default: ;
         endcase
      end
   end

   always_comb begin
      st.pen  = pen_q;
      st.flag = flag_q;
      st.wd   = wd_q;
      st.bl   = bl_q;
      st.wel  = wel_q;
      st.busy = nv_busy;
   end

   // R8: a denied settings write leaves the nonvolatile fields untouched
   p_hold_on_deny_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (op == CMD_STAT_WR && !ok) |=> $stable({pen_q, wd_q, bl_q}));
endmodule

// File: rtl/blocklock_guard.sv
module blocklock_guard
   import blg_pkg::*;
#(
   parameter int         ADDR_W     = 13,
   parameter logic [7:0] RST_STATUS = 8'h00
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [2:0]        cmd,
   input  logic [ADDR_W-1:0] addr,
   input  logic [7:0]        wr_data,
   input  logic              pin_hi,
   input  logic              nv_busy,
   output logic              grant,
   output logic              deny,
   output logic [7:0]        status
);
   initial begin
      assert (STAT_W == 8) else $error("blocklock_guard: status width must be 8");
   end

   cmd_e  op;
   stat_t st;
   logic  locked, is_write, ok;

   assign op = cmd_e'(cmd);

   blg_lock_map #(.ADDR_W(ADDR_W)) u_map (
      .addr   (addr),
      .lvl    (st.bl),
      .locked (locked)
   );

   blg_policy u_pol (
      .op         (op),
      .wel        (st.wel),
      .pen        (st.pen),
      .pin_hi     (pin_hi),
      .arr_locked (locked),
      .is_write   (is_write),
      .ok         (ok)
   );

   blg_status #(.RST_STATUS(RST_STATUS)) u_st (
      .clk     (clk),
      .rst_n   (rst_n),
      .op      (op),
      .ok      (ok),
      .din     (wr_data),
      .nv_busy (nv_busy),
      .st      (st)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         grant <= 1'b0;
         deny  <= 1'b0;
      end else begin
         grant <= is_write & ok;
         deny  <= is_write & ~ok;
      end
   end

   assign status = st;

   // R4: never both answers at once
   p_one_answer_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !(grant && deny));
   // R5: no latch, no write
   p_no_latch_deny_r5: assert property (@(posedge clk) disable iff (!rst_n)
      ((cmd == 3'd5 || cmd == 3'd6) && !status[1]) |=> (deny && !grant));
   // R7: frozen settings refuse a settings write
   p_frozen_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd == 3'd5 && status[7] && !pin_hi) |=> deny);
   // R6: whole-array lock never grants an array write
   p_full_lock_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd == 3'd6 && status[3:2] == 2'b11) |=> !grant);
   // R9: a grant leaves the latch clear
   p_latch_spent_r9: assert property (@(posedge clk) disable iff (!rst_n)
      grant |-> !status[1]);
endmodule

// File: tb/sim_blocklock_guard.sv
module sim_blocklock_guard;
   localparam int AW = 13;
   localparam int SIZE = 1 << AW;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [2:0]    cmd = 3'd0;
   logic [AW-1:0] addr = '0;
   logic [7:0]    wr_data = 8'h00;
   logic          pin_hi = 1'b1;
   logic          nv_busy = 1'b0;
   logic          grant, deny;
   logic [7:0]    status;

   int n_chk = 0;
   int n_bad = 0;
   bit cmp_on = 1'b0;

   always #10 clk = ~clk;

   blocklock_guard #(.ADDR_W(AW), .RST_STATUS(8'h00)) u0 (
      .clk(clk), .rst_n(rst_n), .cmd(cmd), .addr(addr), .wr_data(wr_data),
      .pin_hi(pin_hi), .nv_busy(nv_busy), .grant(grant), .deny(deny),
      .status(status)
   );

   // behavioural reference
   int m_pen, m_flag, m_wd, m_bl, m_wel, m_g, m_d;
   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_pen = 0; m_flag = 0; m_wd = 0; m_bl = 0; m_wel = 0; m_g = 0; m_d = 0;
      end else begin
         int a;
         bit lk;
         m_g = 0; m_d = 0;
         a = int'(addr);
         case (cmd)
            3'd1: m_wel = 1;
            3'd2: m_wel = 0;
            3'd3: m_flag = 1;
            3'd4: m_flag = 0;
            3'd5: if (m_wel == 1 && !(m_pen == 1 && pin_hi == 1'b0)) begin
                     m_pen = wr_data[7]; m_wd = wr_data[5:4]; m_bl = wr_data[3:2];
                     m_wel = 0; m_g = 1;
                  end else m_d = 1;
            3'd6: begin
                     lk = (m_bl == 3) || (m_bl == 2 && a >= SIZE / 2) ||
                          (m_bl == 1 && a >= (SIZE / 4) * 3);
                     if (m_wel == 1 && !lk) begin m_wel = 0; m_g = 1; end
                     else m_d = 1;
                  end
            default: ;
         endcase
      end
   end

   function automatic logic [7:0] m_stat();
      return {m_pen[0], m_flag[0], m_wd[1:0], m_bl[1:0], m_wel[0], nv_busy};
   endfunction

   task automatic chk(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
      end
   endtask

   // per-cycle comparison against the model
   always @(negedge clk) begin
      if (cmp_on) begin
         chk("R2", status, m_stat());
         chk("R4", grant, m_g);
         chk("R4", deny, m_d);
      end
   end

   task automatic issue(input logic [2:0] c, input int a, input logic [7:0] d, input logic p);
      @(negedge clk);
      cmd = c; addr = AW'(a); wr_data = d; pin_hi = p;
      @(negedge clk);
      cmd = 3'd0;
   endtask

   initial begin
      #4000000;
      n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      cmp_on = 1'b1;
      chk("R1", status, 8'h00);
      chk("R1", {grant, deny}, 0);
      nv_busy = 1'b1; #1;
      chk("R2", status[0], 1);
      nv_busy = 1'b0; #1;

      issue(3'd6, 0, 8'h00, 1'b1);               // no latch
      chk("R5", deny, 1);
      chk("R5", status, 8'h00);
      issue(3'd5, 0, 8'hFC, 1'b1);
      chk("R5", {grant, deny}, 1);
      issue(3'd1, 0, 8'h00, 1'b1);
      chk("R3", status, 8'h02);
      issue(3'd7, 0, 8'hFF, 1'b0);
      chk("R3", status, 8'h02);
      chk("R4", {grant, deny}, 0);
      issue(3'd3, 0, 8'h00, 1'b1);
      chk("R3", status, 8'h42);
      issue(3'd4, 0, 8'h00, 1'b1);
      chk("R3", status, 8'h02);
      issue(3'd3, 0, 8'h00, 1'b1);
      issue(3'd6, 'h1FFF, 8'h00, 1'b0);         // level 00
      chk("R6", grant, 1);
      chk("R9", status, 8'h40);
      issue(3'd1, 0, 8'h00, 1'b1);
      issue(3'd5, 0, 8'b1010_1011, 1'b1);       // pen=1 wd=10 bl=10
      chk("R7", grant, 1);
      chk("R8", status, 8'hE8);
      issue(3'd1, 0, 8'h00, 1'b1);
      issue(3'd6, 'h0FFF, 8'h00, 1'b0);
      chk("R11", grant, 1);
      issue(3'd1, 0, 8'h00, 1'b1);
      issue(3'd6, 'h1000, 8'h00, 1'b1);
      chk("R11", deny, 1);
      chk("R9", status, 8'hEA);
      issue(3'd5, 0, 8'h00, 1'b0);              // frozen
      chk("R7", deny, 1);
      chk("R8", status, 8'hEA);
      issue(3'd5, 0, 8'b1000_0100, 1'b1);       // pen=1 bl=01
      pin_hi = 1'b0;
      chk("R10", grant, 1);
      chk("R10", status, 8'hC4);
      @(negedge clk);
      chk("R10", status, 8'hC4);
      issue(3'd1, 0, 8'h00, 1'b0);
      issue(3'd6, 'h17FF, 8'h00, 1'b0);
      chk("R6", grant, 1);
      issue(3'd1, 0, 8'h00, 1'b0);
      issue(3'd6, 'h1800, 8'h00, 1'b1);
      chk("R11", deny, 1);
      issue(3'd5, 0, 8'h0C, 1'b1);              // pen=0 bl=11
      chk("R8", status, 8'h4C);
      issue(3'd1, 0, 8'h00, 1'b1);
      issue(3'd6, 0, 8'h00, 1'b1);
      chk("R6", deny, 1);
      chk("R9", status, 8'h4E);
      issue(3'd5, 0, 8'h00, 1'b0);              // pen=0, pin low
      chk("R7", grant, 1);
      chk("R8", status, 8'h40);

      for (int i = 0; i < 3000; i++) begin
         @(negedge clk);
         cmd     = 3'($urandom_range(0, 7));
         addr    = AW'($urandom);
         wr_data = 8'($urandom);
         pin_hi  = 1'($urandom);
         nv_busy = 1'($urandom);
      end
      @(negedge clk);
      cmd = 3'd0;
      @(negedge clk);
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule